// File: doc/BRIEF.md
# Selectable Bipolar Line Codec (AMI / B8ZS / HDB3)

This block sits between a framer's single-rail bit stream and a bipolar line. The transmit half turns one NRZ data bit per bit period into a pair of rail signals, one for a positive mark and one for a negative mark. In the zero-substitution codes it replaces long runs of zeros with patterns that contain deliberate alternation violations, which keeps the line busy. The receive half takes the two received rails and rebuilds NRZ data. It strips out any valid substitution pattern and raises a one-period strobe on every mark that breaks alternation for no valid reason.

Each direction has its own plain-code select input, so the transmit and receive codes can differ. When a select input is low, the shared three-bit line-length input chooses the substitution code: value 000 selects the four-zero code (HDB3), and any other value selects the eight-zero code (B8ZS). Both halves delay data by a fixed 8 bit periods, which is enough to see a whole eight-zero run before the first of its bits goes out.

The receive half is a two-state machine. In PASS it forwards each head bit, and in STRIP it emits zeros while a recognised pattern drains out. The PASS→STRIP transition fires when a valid pattern is found at the head of the delay line. The STRIP→PASS transition fires when the last bit of that pattern leaves the head.

Top module: `linecodec_top`

## Requirements
- R1: When a code-select input is high, its direction uses AMI. When it is low and line_len is 000, that direction uses HDB3. When it is low and line_len has any other value, that direction uses B8ZS. The two directions are selected independently.
- R2: A tx_bit sampled at clock edge k appears on the transmit rails after edge k+8. tx_pos high means a positive mark and tx_neg high means a negative mark. The two rails are never high together.
- R3: In AMI, each 1 becomes a mark of the opposite polarity to the previous mark, and each 0 becomes no mark. The first mark after reset is positive.
- R4: In B8ZS, each run of eight zeros goes out as 0,0,0,V,B,0,V,B. Here V has the polarity of the preceding mark, and each B is opposite to the pulse just before it. A run of seven or fewer zeros is sent as plain zeros.
- R5: In HDB3, each run of four zeros goes out as 0,0,0,V when an odd number of marks has been sent since the last V (or since reset). Otherwise it goes out as B,0,0,V, where B alternates and V copies the polarity of the pulse before it.
- R6: A rail sample taken at edge k is decoded onto rx_bit after edge k+8. Any pulse that is not part of a removed pattern reads as 1, and no pulse reads as 0.
- R7: In B8ZS and HDB3, a valid substitution pattern is checked against the polarity of the line pulse before it. A valid pattern is decoded as all zeros with no strobe. A pattern shape whose first V does not copy the previous pulse polarity is decoded as ordinary marks.
- R8: rx_bpv goes high for one bit period, together with rx_bit, on any retained pulse whose polarity equals that of the previous line pulse. Substitution pulses count as previous pulses. After reset the previous polarity is taken as negative.
- R9: While reset is held, tx_pos, tx_neg, rx_bit and rx_bpv are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_plain_sel | input | 1 | High: transmit uses AMI |
| rx_plain_sel | input | 1 | High: receive uses AMI |
| line_len | input | 3 | Line-length code; 000 picks HDB3, others B8ZS |
| tx_bit | input | 1 | Transmit NRZ data |
| tx_pos | output | 1 | Transmit positive-mark rail |
| tx_neg | output | 1 | Transmit negative-mark rail |
| rx_pos | input | 1 | Received positive-mark rail |
| rx_neg | input | 1 | Received negative-mark rail |
| rx_bit | output | 1 | Received NRZ data |
| rx_bpv | output | 1 | Bipolar violation strobe |

## Verification
The assertions assume that the code selects and line_len stay fixed while a run is in progress, and that the two receive rails are never high in the same period. The decoder folds a both-high sample to no pulse, and the assertions make no claim about that case. The stimulus changes the selects only inside reset, and it drives the receive rails either from the block's own transmitter or from per-period tables that hold at most one mark each. These tables cover deliberate violations and near-miss pattern shapes, so the strip state and the strobe are exercised beyond what a loopback produces.

// File: rtl/linecodec_pkg.sv
`timescale 1ns/1ps
package linecodec_pkg;

    typedef enum logic [1:0] {CODE_AMI, CODE_B8ZS, CODE_HDB3} code_e;

    // Transmit delay-line symbol: what the slot becomes when it reaches the head
    typedef enum logic [1:0] {SYM_ZERO, SYM_MARK, SYM_VIOL, SYM_HEAD} sym_e;

    typedef enum logic {DEC_PASS, DEC_STRIP} dec_state_e;

    localparam int unsigned LONG_RUN  = 8;
    localparam int unsigned SHORT_RUN = 4;
    localparam int unsigned RUN_W     = $clog2(LONG_RUN + 1);

    function automatic code_e pick_code(input logic plain_sel, input logic [2:0] len_sel);
        if (plain_sel)
            return CODE_AMI;
        else if (len_sel == 3'b000)
            return CODE_HDB3;
        else
            return CODE_B8ZS;
    endfunction

    function automatic logic [RUN_W-1:0] run_of(input code_e c);
        unique case (c)
            CODE_B8ZS: return RUN_W'(LONG_RUN);
            CODE_HDB3: return RUN_W'(SHORT_RUN);
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/lc_encoder.sv
`timescale 1ns/1ps
module lc_encoder
    import linecodec_pkg::*;
#(
    parameter int unsigned PIPE_LEN = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  code_e code,
    input  logic  tx_bit,
    output logic  tx_pos,
    output logic  tx_neg
);
    localparam int unsigned HEAD = PIPE_LEN - 1;
    localparam int unsigned ZW   = 4;

    sym_e            pipe_q [PIPE_LEN];
    sym_e            pipe_d [PIPE_LEN];
    logic [ZW-1:0]   zrun_q, zrun_d;
    logic [RUN_W-1:0] run_len;
    logic            hit;
    logic            last_pos_q;   // polarity of last emitted pulse, 1 = positive
    logic            odd_q;        // odd count of alternating marks since last V

    assign run_len = run_of(code);
    assign hit     = !tx_bit && (code != CODE_AMI)
                     && (({1'b0, zrun_q} + 5'd1) >= {{(5-RUN_W){1'b0}}, run_len});

    always_comb begin
        pipe_d[0] = tx_bit ? SYM_MARK : SYM_ZERO;
        for (int i = 1; i < PIPE_LEN; i++)
            pipe_d[i] = pipe_q[i-1];
        if (tx_bit || hit)
            zrun_d = '0;
        else if (zrun_q != {ZW{1'b1}})
            zrun_d = zrun_q + 1'b1;
        else
            zrun_d = zrun_q;
        if (hit && code == CODE_B8ZS) begin
            pipe_d[7] = SYM_ZERO; pipe_d[6] = SYM_ZERO; pipe_d[5] = SYM_ZERO;
            pipe_d[4] = SYM_VIOL; pipe_d[3] = SYM_MARK; pipe_d[2] = SYM_ZERO;
            pipe_d[1] = SYM_VIOL; pipe_d[0] = SYM_MARK;
        end else if (hit && code == CODE_HDB3) begin
            pipe_d[3] = SYM_HEAD; pipe_d[2] = SYM_ZERO;
            pipe_d[1] = SYM_ZERO; pipe_d[0] = SYM_VIOL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PIPE_LEN; i++)
                pipe_q[i] <= SYM_ZERO;
            zrun_q <= '0;
        end else begin
            for (int i = 0; i < PIPE_LEN; i++)
                pipe_q[i] <= pipe_d[i];
            zrun_q <= zrun_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_pos     <= 1'b0;
            tx_neg     <= 1'b0;
            last_pos_q <= 1'b0;
            odd_q      <= 1'b0;
        end else begin
            tx_pos <= 1'b0;
            tx_neg <= 1'b0;
            unique case (pipe_q[HEAD])
                SYM_ZERO: ;
                SYM_MARK: begin
                    tx_pos     <= !last_pos_q;
                    tx_neg     <= last_pos_q;
                    last_pos_q <= !last_pos_q;
                    odd_q      <= !odd_q;
                end
                SYM_VIOL: begin
                    tx_pos <= last_pos_q;
                    tx_neg <= !last_pos_q;
                    odd_q  <= 1'b0;
                end
                SYM_HEAD: begin
                    if (!odd_q) begin
                        tx_pos     <= !last_pos_q;
                        tx_neg     <= last_pos_q;
                        last_pos_q <= !last_pos_q;
                        odd_q      <= 1'b1;
                    end
                end
            endcase
        end
    end

    // R2: a period carries at most one mark polarity
    p_rails_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_pos && tx_neg));

endmodule

// File: rtl/lc_decoder.sv
`timescale 1ns/1ps
module lc_decoder
    import linecodec_pkg::*;
#(
    parameter int unsigned PIPE_LEN = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  code_e code,
    input  logic  rx_pos,
    input  logic  rx_neg,
    output logic  rx_bit,
    output logic  rx_bpv
);
    localparam int unsigned H = PIPE_LEN - 1;

    logic [1:0]       pipe_q [PIPE_LEN];   // {pos, neg}
    logic [1:0]       head, vslot;
    logic             head_pulse;
    logic             b8_match, hd_match, match;
    logic             last_pos_q;
    dec_state_e       state_q, state_d;
    logic [RUN_W-1:0] strip_q, strip_d;

    assign head       = pipe_q[H];
    assign head_pulse = head != 2'b00;
    assign vslot      = pipe_q[H-3];

    always_comb begin
        b8_match = (code == CODE_B8ZS)
            && head == 2'b00 && pipe_q[H-1] == 2'b00 && pipe_q[H-2] == 2'b00
            && vslot != 2'b00 && vslot[1] == last_pos_q
            && pipe_q[H-4] == {vslot[0], vslot[1]}
            && pipe_q[H-5] == 2'b00
            && pipe_q[H-6] == pipe_q[H-4]
            && pipe_q[H-7] == vslot;
        hd_match = (code == CODE_HDB3)
            && pipe_q[H-1] == 2'b00 && pipe_q[H-2] == 2'b00 && vslot != 2'b00
            && ((head == 2'b00 && vslot[1] == last_pos_q)
                || (head_pulse && head[1] != last_pos_q && head == vslot));
        match = b8_match || hd_match;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PIPE_LEN; i++)
                pipe_q[i] <= 2'b00;
        end else begin
            pipe_q[0] <= {rx_pos & ~rx_neg, rx_neg & ~rx_pos};
            for (int i = 1; i < PIPE_LEN; i++)
                pipe_q[i] <= pipe_q[i-1];
        end
    end

    always_comb begin
        state_d = state_q;
        strip_d = strip_q;
        unique case (state_q)
            DEC_PASS: begin
                if (match) begin
                    state_d = DEC_STRIP;
                    strip_d = run_of(code) - 1'b1;
                end
            end
            DEC_STRIP: begin
                strip_d = strip_q - 1'b1;
                if (strip_q == RUN_W'(1))
                    state_d = DEC_PASS;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DEC_PASS;
            strip_q <= '0;
        end else begin
            state_q <= state_d;
            strip_q <= strip_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_bit     <= 1'b0;
            rx_bpv     <= 1'b0;
            last_pos_q <= 1'b0;
        end else begin
            if (head_pulse)
                last_pos_q <= head[1];
            unique case (state_q)
                DEC_PASS: begin
                    rx_bit <= head_pulse && !match;
                    rx_bpv <= head_pulse && !match && (head[1] == last_pos_q);
                end
                DEC_STRIP: begin
                    rx_bit <= 1'b0;
                    rx_bpv <= 1'b0;
                end
            endcase
        end
    end

    // R8: a strobe always rides on a decoded mark
    p_bpv_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bpv |-> rx_bit);

    // R7: while a pattern drains, output stays zero with no strobe
    p_strip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DEC_STRIP) |=> (!rx_bit && !rx_bpv));

    // R7: the drain counter is live throughout STRIP
    p_strip_cnt_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DEC_STRIP) |-> (strip_q != '0));

endmodule

// File: rtl/linecodec_top.sv
`timescale 1ns/1ps
module linecodec_top
    import linecodec_pkg::*;
#(
    parameter int unsigned PIPE_LEN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_plain_sel,
    input  logic       rx_plain_sel,
    input  logic [2:0] line_len,
    input  logic       tx_bit,
    output logic       tx_pos,
    output logic       tx_neg,
    input  logic       rx_pos,
    input  logic       rx_neg,
    output logic       rx_bit,
    output logic       rx_bpv
);
    code_e tx_code, rx_code;

    assign tx_code = pick_code(tx_plain_sel, line_len);
    assign rx_code = pick_code(rx_plain_sel, line_len);

    lc_encoder #(.PIPE_LEN(PIPE_LEN)) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (tx_code),
        .tx_bit (tx_bit),
        .tx_pos (tx_pos),
        .tx_neg (tx_neg)
    );

    lc_decoder #(.PIPE_LEN(PIPE_LEN)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (rx_code),
        .rx_pos (rx_pos),
        .rx_neg (rx_neg),
        .rx_bit (rx_bit),
        .rx_bpv (rx_bpv)
    );

endmodule

// File: tb/linecodec_top_bench.sv
`timescale 1ns/1ps
module linecodec_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_plain_sel = 1'b1, rx_plain_sel = 1'b1;
    logic [2:0] line_len = 3'b000;
    logic       tx_bit = 1'b0, drv_pos = 1'b0, drv_neg = 1'b0, loop_en = 1'b0;
    logic       tx_pos, tx_neg, rx_bit, rx_bpv;
    logic       rx_pos_w, rx_neg_w;

    int tests_run = 0;
    int tests_failed = 0;

    always #2.5 clk = ~clk;

    assign rx_pos_w = loop_en ? tx_pos : drv_pos;
    assign rx_neg_w = loop_en ? tx_neg : drv_neg;

    linecodec_top u_linecodec_top (
        .clk(clk), .rst_n(rst_n), .tx_plain_sel(tx_plain_sel), .rx_plain_sel(rx_plain_sel),
        .line_len(line_len), .tx_bit(tx_bit), .tx_pos(tx_pos), .tx_neg(tx_neg),
        .rx_pos(rx_pos_w), .rx_neg(rx_neg_w), .rx_bit(rx_bit), .rx_bpv(rx_bpv)
    );

    typedef struct packed {
        logic        plain;
        logic [2:0]  len;
        logic [15:0] din;
        logic [15:0] pos;
        logic [15:0] neg;
    } vec_t;

    // first bit in time is the MSB
    localparam vec_t [0:3] VECS = '{
        '{1'b1, 3'b000, 16'hB00D, 16'h9004, 16'h2009},   // R3 AMI
        '{1'b0, 3'b011, 16'h8063, 16'h88A1, 16'h0542},   // R4 B8ZS eight zeros
        '{1'b0, 3'b000, 16'h8601, 16'h8A12, 16'h0521},   // R5 HDB3 both forms
        '{1'b0, 3'b111, 16'h8081, 16'h8001, 16'h0080}    // R4 seven zeros kept
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic tsel, input logic rsel, input logic [2:0] len);
        rst_n = 1'b0;
        tx_bit = 1'b0; drv_pos = 1'b0; drv_neg = 1'b0;
        tx_plain_sel = tsel; rx_plain_sel = rsel; line_len = len;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_loop(input logic tsel, input logic rsel, input logic [2:0] len,
                            input logic [15:0] din,
                            output logic [15:0] p, output logic [15:0] n,
                            output logic [15:0] rb, output logic [15:0] bv);
        p = '0; n = '0; rb = '0; bv = '0;
        loop_en = 1'b1;
        do_reset(tsel, rsel, len);
        for (int c = 0; c <= 40; c++) begin
            @(negedge clk);
            if (c >= 9 && c < 25) begin
                p[24-c] = tx_pos;
                n[24-c] = tx_neg;
            end
            if (c >= 18 && c < 34) begin
                rb[33-c] = rx_bit;
                bv[33-c] = rx_bpv;
            end
            tx_bit = (c < 16) ? din[15-c] : 1'b0;
        end
    endtask

    task automatic run_rx(input logic rsel, input logic [2:0] len,
                          input logic [15:0] p, input logic [15:0] n,
                          output logic [15:0] rb, output logic [15:0] bv);
        rb = '0; bv = '0;
        loop_en = 1'b0;
        do_reset(1'b1, rsel, len);
        for (int c = 0; c <= 30; c++) begin
            @(negedge clk);
            if (c >= 9 && c < 25) begin
                rb[24-c] = rx_bit;
                bv[24-c] = rx_bpv;
            end
            drv_pos = (c < 16) ? p[15-c] : 1'b0;
            drv_neg = (c < 16) ? n[15-c] : 1'b0;
        end
    endtask

    initial begin
        #500000;
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        logic [15:0] p, n, rb, bv;

        // R9: reset state, sampled while reset is held
        tx_plain_sel = 1'b0; line_len = 3'b000;
        rst_n = 1'b0; tx_bit = 1'b1; drv_pos = 1'b1; loop_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 tx_pos in reset", 32'(tx_pos), 32'd0);
        check("R9 tx_neg in reset", 32'(tx_neg), 32'd0);
        check("R9 rx_bit in reset", 32'(rx_bit), 32'd0);
        check("R9 rx_bpv in reset", 32'(rx_bpv), 32'd0);

        // Table walk: encoder rails, then loopback through a matching decoder
        for (int v = 0; v < 4; v++) begin
            run_loop(VECS[v].plain, VECS[v].plain, VECS[v].len, VECS[v].din, p, n, rb, bv);
            check($sformatf("R1 R2 vec%0d tx_pos", v), 32'(p), 32'(VECS[v].pos));
            check($sformatf("R1 R2 vec%0d tx_neg", v), 32'(n), 32'(VECS[v].neg));
            check($sformatf("R6 R7 vec%0d rx_bit", v), 32'(rb), 32'(VECS[v].din));
            check($sformatf("R8 vec%0d rx_bpv", v), 32'(bv), 32'd0);
        end

        // R1: transmit HDB3, receive AMI: substitution pulses kept, violations flagged
        run_loop(1'b0, 1'b1, 3'b000, 16'h8601, p, n, rb, bv);
        check("R1 split codes rx_bit", 32'(rb), 32'h8F33);
        check("R1 split codes rx_bpv", 32'(bv), 32'h0822);

        // R8: AMI violations, including a negative first pulse after reset
        run_rx(1'b1, 3'b000, 16'h6000, 16'h8C00, rb, bv);
        check("R6 AMI rx_bit", 32'(rb), 32'hEC00);
        check("R8 AMI rx_bpv", 32'(bv), 32'hA400);

        // R7/R8: HDB3 lone violation flagged, valid B00V removed
        run_rx(1'b0, 3'b000, 16'hA080, 16'h0900, rb, bv);
        check("R7 HDB3 rx_bit", 32'(rb), 32'hA080);
        check("R8 HDB3 rx_bpv", 32'(bv), 32'h2000);

        // R7: B8ZS shape with wrong leading polarity is not removed
        run_rx(1'b0, 3'b010, 16'h8440, 16'h4280, rb, bv);
        check("R7 B8ZS near-miss rx_bit", 32'(rb), 32'hC6C0);
        check("R8 B8ZS near-miss rx_bpv", 32'(bv), 32'h0080);

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule